// File: doc/BRIEF.md
# Outbound Memory Window Address Translator

This block maps addresses issued on the local bus into PCI memory addresses. A 64 MB aperture on the local bus is split into four 16 MB slices, and each slice can be pointed at any 16 MB region of the 4 GB PCI memory space. A single 32-bit window register holds one 8-bit page field per slice. A translated address keeps the low 24 bits of the incoming address and takes its top byte from the field of the selected slice.

The window register sits behind a small register port shared by two requesters: the local bus side, which may read and write it, and the PCI side, which may only read it. Byte enables let software move one window without disturbing the other three. Translation requests are accepted every cycle and answered one cycle later. A request outside the aperture is answered with an error flag instead of an address.

Top module: `obwin_xlat`

## Requirements
- R1: After reset the window register reads as 0x00000000 and `out_valid` and `out_err` are low.
- R2: Field layout: window 0 occupies register bits 31:24, window 1 bits 23:16, window 2 bits 15:8 and window 3 bits 7:0. Byte enable bit j (`reg_be[j]`) covers register bits 8j+7:8j, so `reg_be[3]` writes window 0.
- R3: A write with `reg_side` = 0 (local side) to byte offset 0x34 updates exactly the enabled bytes from `reg_wdata`. The other bytes keep their values.
- R4: A write with `reg_side` = 1 (PCI side) leaves the register unchanged. A write to any offset other than 0x34 leaves the register unchanged.
- R5: A read at offset 0x34 from either side returns the register value in the same cycle. A read at any other offset returns 0.
- R6: A request is inside the aperture when `req_addr[31:26]` equals bits 31:26 of `APERTURE_BASE` (default 0x48000000). Bits 25:24 then select window 0 to 3.
- R7: One cycle after a request inside the aperture, `out_valid` is high, `out_err` is low and `out_addr` = {selected window field, `req_addr[23:0]`}.
- R8: One cycle after a request outside the aperture, `out_valid` and `out_err` are high and `out_addr` is 0.
- R9: A request made in the same cycle as a register write is translated with the field value from before the write. The new value applies to requests from the next cycle on.
- R10: One cycle after a cycle without a request, `out_valid`, `out_err` and `out_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_side | input | 1 | Requester of the register access: 0 local bus, 1 PCI |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the offset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local bus address to translate |
| out_valid | output | 1 | Translated result valid, one cycle after the request |
| out_err | output | 1 | Request fell outside the aperture |
| out_addr | output | 32 | Translated PCI memory address |

## Verification
A register write and a translation request can arrive in the same cycle. A request that reads the window being rewritten must then see the old field. The bench provokes this with directed cycles that rewrite a window while translating through it, followed by the same request one cycle later. It also mixes random writes and requests at random. Each result is compared against a reference register that the bench updates only after it has computed the expected translation for that cycle.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

    // Requester of a register access
    typedef enum logic {
        SIDE_LOCAL = 1'b0,
        SIDE_PCI   = 1'b1
    } side_e;

endpackage

// File: rtl/obwin_regfile.sv
module obwin_regfile #(
    parameter int          WIN_CNT = 4,
    parameter int          FIELD_W = 8,
    parameter int          OFS_W   = 8,
    parameter logic [7:0]  REG_OFS = 8'h34,
    localparam int         REG_W   = WIN_CNT * FIELD_W,
    localparam int         BE_W    = REG_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  obwin_pkg::side_e     side,
    input  logic                 wr,
    input  logic [OFS_W-1:0]     addr,
    input  logic [BE_W-1:0]      be,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic [REG_W-1:0]     win_o
);
    import obwin_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] win;
    } state_t;

    state_t st_d, st_q;
    logic   hit;
    logic   wr_ok;

    always_comb begin
        hit   = (addr == OFS_W'(REG_OFS));
        wr_ok = wr && hit && (side == SIDE_LOCAL);
        st_d  = st_q;
        for (int j = 0; j < BE_W; j++) begin
            if (wr_ok && be[j]) begin
                st_d.win[j*8 +: 8] = wdata[j*8 +: 8];
            end
        end
        rdata = hit ? st_q.win : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o = st_q.win;

    for (genvar j = 0; j < BE_W; j++) begin : g_byte_chk
        AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && side == SIDE_LOCAL && addr == OFS_W'(REG_OFS) && be[j])
            |=> $stable(win_o[j*8 +: 8])); // R4
        AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && side == SIDE_LOCAL && addr == OFS_W'(REG_OFS) && be[j])
            |=> win_o[j*8 +: 8] == $past(wdata[j*8 +: 8])); // R3
    end

    AST_PCI_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (side == SIDE_PCI) |=> $stable(win_o)); // R4

endmodule

// File: rtl/obwin_translate.sv
module obwin_translate #(
    parameter int                  ADDR_W        = 32,
    parameter int                  WIN_CNT       = 4,
    parameter int                  PASS_W        = 24,
    parameter logic [ADDR_W-1:0]   APERTURE_BASE = 32'h4800_0000,
    localparam int                 FIELD_W       = ADDR_W - PASS_W,
    localparam int                 SEL_W         = $clog2(WIN_CNT),
    localparam int                 TAG_LO        = PASS_W + SEL_W,
    localparam int                 REG_W         = WIN_CNT * FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_W-1:0]     win_i,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 out_valid,
    output logic                 out_err,
    output logic [ADDR_W-1:0]    out_addr
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t              st_d, st_q;
    logic [FIELD_W-1:0]  fld [WIN_CNT];
    logic [SEL_W-1:0]    sel;
    logic                in_ap;

    // Window 0 sits in the most significant field
    for (genvar i = 0; i < WIN_CNT; i++) begin : g_fld
        assign fld[i] = win_i[(WIN_CNT-1-i)*FIELD_W +: FIELD_W];
    end

    always_comb begin
        sel   = req_addr[PASS_W +: SEL_W];
        in_ap = (req_addr[ADDR_W-1:TAG_LO] == APERTURE_BASE[ADDR_W-1:TAG_LO]);
        st_d  = '0;
        if (req_valid) begin
            st_d.valid = 1'b1;
            if (in_ap) begin
                st_d.addr = {fld[sel], req_addr[PASS_W-1:0]};
            end else begin
                st_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_err   = st_q.err;
    assign out_addr  = st_q.addr;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_err && out_addr == '0)); // R10
    AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_addr == '0)); // R8
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> out_addr[PASS_W-1:0] == $past(req_addr[PASS_W-1:0])); // R7
    AST_OLD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !$isunknown(req_addr) &&
         req_addr[ADDR_W-1:TAG_LO] == APERTURE_BASE[ADDR_W-1:TAG_LO])
        |=> out_addr[ADDR_W-1:PASS_W] ==
            $past(win_i[(WIN_CNT-1-int'(req_addr[PASS_W +: SEL_W]))*FIELD_W +: FIELD_W])); // R9

endmodule

// File: rtl/obwin_xlat.sv
module obwin_xlat #(
    parameter int           ADDR_W        = 32,
    parameter int           WIN_CNT       = 4,
    parameter int           PASS_W        = 24,
    parameter int           OFS_W         = 8,
    parameter logic [7:0]   REG_OFS       = 8'h34,
    parameter logic [31:0]  APERTURE_BASE = 32'h4800_0000,
    localparam int          FIELD_W       = ADDR_W - PASS_W,
    localparam int          REG_W         = WIN_CNT * FIELD_W,
    localparam int          BE_W          = REG_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_side,
    input  logic                 reg_wr,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [BE_W-1:0]      reg_be,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 out_valid,
    output logic                 out_err,
    output logic [ADDR_W-1:0]    out_addr
);
    import obwin_pkg::*;

    logic [REG_W-1:0] win;
    side_e            side;

    assign side = side_e'(reg_side);

    obwin_regfile #(
        .WIN_CNT (WIN_CNT),
        .FIELD_W (FIELD_W),
        .OFS_W   (OFS_W),
        .REG_OFS (REG_OFS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .side  (side),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .win_o (win)
    );

    obwin_translate #(
        .ADDR_W        (ADDR_W),
        .WIN_CNT       (WIN_CNT),
        .PASS_W        (PASS_W),
        .APERTURE_BASE (ADDR_W'(APERTURE_BASE))
    ) u_xlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_i     (win),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .out_valid (out_valid),
        .out_err   (out_err),
        .out_addr  (out_addr)
    );

endmodule

// File: tb/obwin_xlat_bench.sv
module obwin_xlat_bench;

    localparam logic [31:0] AP = 32'h4800_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_side;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        out_valid;
    logic        out_err;
    logic [31:0] out_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    obwin_xlat u_obwin_xlat (
        .clk(clk), .rst_n(rst_n),
        .reg_side(reg_side), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] field_of(logic [31:0] r, int w);
        return r[(3-w)*8 +: 8];
    endfunction

    function automatic logic in_aperture(logic [31:0] a);
        return a[31:26] == AP[31:26];
    endfunction

    function automatic logic [31:0] exp_addr(logic [31:0] r, logic [31:0] a);
        if (!in_aperture(a)) return '0;
        return {field_of(r, int'(a[25:24])), a[23:0]};
    endfunction

    function automatic logic [31:0] apply_wr(logic [31:0] r, logic side, logic wr,
                                             logic [7:0] ofs, logic [3:0] be, logic [31:0] d);
        logic [31:0] n = r;
        if (wr && !side && ofs == 8'h34)
            for (int j = 0; j < 4; j++) if (be[j]) n[j*8 +: 8] = d[j*8 +: 8];
        return n;
    endfunction

    // One cycle: drive at negedge, check read, clock, check translation
    task automatic step(string req, logic side, logic wr, logic [7:0] ofs, logic [3:0] be,
                        logic [31:0] d, logic rv, logic [31:0] ra);
        logic [31:0] ea;
        logic        ev, ee;
        reg_side = side; reg_wr = wr; reg_addr = ofs; reg_be = be; reg_wdata = d;
        req_valid = rv; req_addr = ra;
        #1;
        check({req, " R5 read"}, reg_rdata, (ofs == 8'h34) ? model : 32'h0);
        ev = rv;
        ee = rv && !in_aperture(ra);
        ea = rv ? exp_addr(model, ra) : '0;
        @(posedge clk);
        model = apply_wr(model, side, wr, ofs, be, d);
        @(negedge clk);
        check({req, " valid"}, {31'b0, out_valid}, {31'b0, ev});
        check({req, " err"},   {31'b0, out_err},   {31'b0, ee});
        check({req, " addr"},  out_addr, ea);
    endtask

    task automatic rd(string req, logic side);
        step(req, side, 1'b0, 8'h34, 4'h0, 32'h0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; reg_side = 0; reg_wr = 0; reg_addr = 0; reg_be = 0; reg_wdata = 0;
        req_valid = 0; req_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 reg", reg_rdata, 32'h0);
        check("R1 valid", {31'b0, out_valid}, 32'h0);
        check("R1 err", {31'b0, out_err}, 32'h0);

        // R2 R3: one byte at a time, window 0 through byte enable 3
        step("R2 R3 w0", 0, 1, 8'h34, 4'b1000, 32'hA1B2C3D4, 0, 0);
        check("R2 w0 field", reg_rdata, 32'hA1000000);
        step("R2 R3 w3", 0, 1, 8'h34, 4'b0001, 32'h111111EE, 0, 0);
        check("R2 w3 field", reg_rdata, 32'hA10000EE);
        step("R3 w1w2", 0, 1, 8'h34, 4'b0110, 32'hFF5566FF, 0, 0);
        check("R3 merged", reg_rdata, 32'hA15566EE);
        // R4 PCI write ignored, wrong offset ignored
        step("R4 pci wr", 1, 1, 8'h34, 4'hF, 32'h0, 0, 0);
        rd("R4 after pci wr", 1);
        check("R4 pci wr no effect", reg_rdata, 32'hA15566EE);
        step("R4 bad ofs", 0, 1, 8'h30, 4'hF, 32'h0, 0, 0);
        rd("R4 after bad ofs", 0);
        check("R4 bad ofs no effect", reg_rdata, 32'hA15566EE);
        // R5 read at other offset
        step("R5 other ofs", 1, 0, 8'h38, 4'h0, 0, 0, 0);
        // R6 R7 each window
        for (int w = 0; w < 4; w++)
            step("R6 R7 window", 0, 0, 8'h00, 0, 0, 1, AP | (32'(w) << 24) | 32'h00ABCDEF);
        step("R7 top of window", 0, 0, 8'h00, 0, 0, 1, AP | 32'h03FFFFFF);
        // R8 outside aperture, below and above
        step("R8 below", 0, 0, 0, 0, 0, 1, AP - 32'h1);
        step("R8 above", 0, 0, 0, 0, 0, 1, AP + 32'h0400_0000);
        // R9 write and request same cycle, then request again
        step("R9 same cycle", 0, 1, 8'h34, 4'b0100, 32'h0077_0000, 1, AP | 32'h0112_3456);
        check("R9 old field", out_addr, 32'h55123456);
        step("R9 next cycle", 0, 0, 0, 0, 0, 1, AP | 32'h0112_3456);
        check("R9 new field", out_addr, 32'h77123456);
        // R9 PCI write same cycle has no effect on translation
        step("R9 R4 pci same cycle", 1, 1, 8'h34, 4'hF, 32'h0, 1, AP | 32'h0012_3456);
        // R10 idle
        step("R10 idle", 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic [7:0]  ofs;
            ra  = ($urandom % 4 != 0) ? (AP | ($urandom & 32'h03FF_FFFF)) : $urandom;
            ofs = ($urandom % 4 != 0) ? 8'h34 : 8'($urandom);
            step("R3 R4 R7 R8 R9 random", 1'($urandom), 1'($urandom), ofs, 4'($urandom),
                 $urandom, 1'($urandom % 3 != 0), ra);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule